// File: doc/BRIEF.md
# Bus Suspend and Wake-up Controller

This block decides when a full-speed device should drop into its low-power suspended state and when it should come back out. A 12 MHz tick paces an idle timer. When the line-state input reports an idle bus for an unbroken 3 ms, the block enters suspend. It then sets a sticky status bit and can raise an interrupt.

While suspended, any of four events wakes the device: a host resume seen on the line, a bus reset, the local wake-up pin, or a firmware wake command. The block records whether the local pin caused the wake. If a host event arrives in the same cycle as the pin, the host event takes priority. A pin wake also drives upstream resume signalling for a fixed number of ticks. A firmware wake leaves the device the same way but sends nothing upstream.

Top module: `susp_wake_ctrl`

## Requirements
- R1: Once reset is released, suspended, susp_status, irq, wake_src and resume_drive are all 0.
- R2: The block enters suspend on the clock edge that completes IDLE_TICKS consecutive ticks with line_idle high. Any cycle with line_idle low restarts the count, and cycles without tick are not counted.
- R3: Entering suspend sets susp_status. irq equals susp_status AND susp_ie at all times.
- R4: A one-cycle pulse on susp_clr (a write of 1) clears susp_status. If suspend entry happens in the same cycle, entry wins and the status stays 1.
- R5: While suspended, a high level on line_resume, line_reset, wake_pin or fw_wake clears suspended on the next clock edge. With none of them high, suspended stays 1.
- R6: On each wake, wake_src becomes 1 only when wake_pin was high and neither line_resume nor line_reset was high. A host resume, a bus reset or a firmware-only wake sets wake_src to 0.
- R7: A pin wake (wake_src becoming 1) raises resume_drive on the same edge. It stays high for RESUME_TICKS ticks and then falls. Any other wake leaves resume_drive at 0.
- R8: When the block is not suspended, the wake inputs have no effect: wake_src keeps its value and resume_drive does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle 12 MHz time-base enable |
| line_idle | input | 1 | Bus line is in the idle state |
| line_resume | input | 1 | Host resume signalling seen on the bus |
| line_reset | input | 1 | Bus reset seen on the bus |
| wake_pin | input | 1 | Local remote wake-up request |
| fw_wake | input | 1 | Firmware wake command, no upstream signalling |
| susp_ie | input | 1 | Suspend interrupt enable |
| susp_clr | input | 1 | Write-1 pulse clearing the suspend status |
| suspended | output | 1 | Device is in the suspended state |
| susp_status | output | 1 | Sticky suspend-detected status |
| irq | output | 1 | Suspend interrupt request |
| wake_src | output | 1 | 1 when the last wake came from the local pin |
| resume_drive | output | 1 | Request to drive resume signalling upstream |

## Verification
Suspend entry lands on the edge of the IDLE_TICKS-th idle tick. Every wake effect, covering suspended, wake_src and the rise of resume_drive, appears one edge after the wake input is applied. resume_drive falls RESUME_TICKS tick-edges after it rose, and irq follows status and enable with no delay. The bench changes inputs just after a falling edge and samples just after the falling edge that follows the edge where each result is due. Each check is placed at its exact cycle, with a companion check one cycle earlier to confirm the result has not yet appeared. Restart of the idle count is swept over every gap position, and the wake priority over all sixteen input combinations.

// File: rtl/susp_wake_ctrl.sv
module susp_wake_ctrl #(
  parameter int IDLE_TICKS   = 36000,
  parameter int RESUME_TICKS = 120000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_idle,
  input  logic line_resume,
  input  logic line_reset,
  input  logic wake_pin,
  input  logic fw_wake,
  input  logic susp_ie,
  input  logic susp_clr,
  output logic suspended,
  output logic susp_status,
  output logic irq,
  output logic wake_src,
  output logic resume_drive
);
  localparam int IW = $clog2(IDLE_TICKS + 1);
  localparam int RW = $clog2(RESUME_TICKS + 1);

  logic [IW-1:0] idle_cnt;
  logic [RW-1:0] res_cnt;

  wire host_wake = line_resume | line_reset;
  wire any_wake  = host_wake | wake_pin | fw_wake;
  wire enter     = !suspended && tick && line_idle && idle_cnt == IW'(IDLE_TICKS - 1);
  wire leave     = suspended && any_wake;
  wire pin_win   = leave && wake_pin && !host_wake;

  assign irq = susp_status & susp_ie;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                 idle_cnt <= '0;
    else if (suspended || !line_idle || enter)  idle_cnt <= '0;
    else if (tick)                              idle_cnt <= idle_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      suspended <= 1'b0;
    else if (enter)  suspended <= 1'b1;
    else if (leave)  suspended <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         susp_status <= 1'b0;
    else if (enter)     susp_status <= 1'b1;
    else if (susp_clr)  susp_status <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      wake_src <= 1'b0;
    else if (leave)  wake_src <= pin_win;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      resume_drive <= 1'b0;
      res_cnt      <= '0;
    end else if (pin_win) begin
      resume_drive <= 1'b1;
      res_cnt      <= '0;
    end else if (resume_drive && tick) begin
      if (res_cnt == RW'(RESUME_TICKS - 1)) resume_drive <= 1'b0;
      else                                  res_cnt <= res_cnt + 1'b1;
    end

  a_r2_entry_needs_idle_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> $past(line_idle) && $past(tick));

  a_r3_status_set_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_status) |-> $rose(suspended));

  a_r5_exit_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(suspended) |-> $past(line_resume || line_reset || wake_pin || fw_wake));

  a_r6_src_changes_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wake_src) |-> $fell(suspended));

  a_r7_drive_from_pin_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_drive) |-> $past(wake_pin) && !$past(line_resume) && !$past(line_reset) && wake_src);

  a_r8_no_drive_while_awake: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(suspended) |-> !$rose(resume_drive));
endmodule

// File: tb/sim_susp_wake_ctrl.sv
`timescale 1ns/1ps
module sim_susp_wake_ctrl;
  localparam int N = 6;
  localparam int R = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b1, line_idle = 1'b0, line_resume = 1'b0, line_reset = 1'b0;
  logic wake_pin = 1'b0, fw_wake = 1'b0, susp_ie = 1'b0, susp_clr = 1'b0;
  logic suspended, susp_status, irq, wake_src, resume_drive;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  susp_wake_ctrl #(.IDLE_TICKS(N), .RESUME_TICKS(R)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_idle(line_idle),
    .line_resume(line_resume), .line_reset(line_reset), .wake_pin(wake_pin),
    .fw_wake(fw_wake), .susp_ie(susp_ie), .susp_clr(susp_clr),
    .suspended(suspended), .susp_status(susp_status), .irq(irq),
    .wake_src(wake_src), .resume_drive(resume_drive));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic go_suspend();
    line_idle = 1'b1;
    step(N - 1);
    chk("R2 not yet suspended", suspended, 1'b0);
    step(1);
    chk("R2 suspended after N idle ticks", suspended, 1'b1);
    line_idle = 1'b0;
  endtask

  task automatic host_wake();
    line_resume = 1'b1;
    step(1);
    line_resume = 1'b0;
    chk("R5 resume wakes", suspended, 1'b0);
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    chk("R1 suspended", suspended, 1'b0);
    chk("R1 status", susp_status, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 wake_src", wake_src, 1'b0);
    chk("R1 resume_drive", resume_drive, 1'b0);

    go_suspend();
    chk("R3 status set", susp_status, 1'b1);
    chk("R3 irq masked", irq, 1'b0);
    susp_ie = 1'b1;
    #1 chk("R3 irq enabled", irq, 1'b1);
    step(3);
    chk("R5 holds without event", suspended, 1'b1);
    host_wake();
    susp_clr = 1'b1;
    step(1);
    susp_clr = 1'b0;
    chk("R4 status cleared", susp_status, 1'b0);
    chk("R3 irq follows status", irq, 1'b0);

    // R4: entry and clear in the same cycle
    line_idle = 1'b1;
    step(N - 1);
    susp_clr = 1'b1;
    step(1);
    susp_clr = 1'b0;
    line_idle = 1'b0;
    chk("R4 entry wins over clear", susp_status, 1'b1);
    host_wake();

    // R2: restart sweep
    for (int g = 1; g < N; g++) begin
      line_idle = 1'b1;
      step(g);
      line_idle = 1'b0;
      step(1);
      go_suspend();
      host_wake();
    end

    // R2: only ticks count
    line_idle = 1'b1;
    for (int i = 0; i < 2 * N - 2; i++) begin
      tick = (i % 2 == 0);
      step(1);
    end
    chk("R2 gated ticks not yet", suspended, 1'b0);
    tick = 1'b1;
    step(1);
    chk("R2 gated ticks suspended", suspended, 1'b1);
    line_idle = 1'b0;
    host_wake();

    // R5 R6 R7: every wake combination
    for (int c = 1; c < 16; c++) begin
      logic e;
      e = (c[2] && !c[0] && !c[1]);
      go_suspend();
      line_reset = c[0]; line_resume = c[1]; wake_pin = c[2]; fw_wake = c[3];
      step(1);
      line_reset = 1'b0; line_resume = 1'b0; wake_pin = 1'b0; fw_wake = 1'b0;
      chk("R5 combo wakes", suspended, 1'b0);
      chk("R6 wake source", wake_src, e);
      chk("R7 drive start", resume_drive, e);
      step(R - 1);
      chk("R7 drive held", resume_drive, e);
      step(1);
      chk("R7 drive released", resume_drive, 1'b0);
    end

    // R8: wake inputs ignored while awake
    go_suspend();
    wake_pin = 1'b1;
    step(1);
    wake_pin = 1'b0;
    step(R);
    chk("R8 setup pin source", wake_src, 1'b1);
    line_reset = 1'b1; fw_wake = 1'b1;
    step(1);
    line_reset = 1'b0; fw_wake = 1'b0;
    chk("R8 source kept", wake_src, 1'b1);
    line_resume = 1'b0;
    wake_pin = 1'b1;
    step(1);
    wake_pin = 1'b0;
    chk("R8 no drive while awake", resume_drive, 1'b0);
    chk("R8 still awake", suspended, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule